// File: doc/BRIEF.md
# Host Instruction Queue Shadow Tracker

This block sits next to a host processor on its local bus and keeps a byte-exact copy of the host's instruction prefetch queue. It does not fetch anything itself. It takes code bytes off the data bus whenever the host completes a code fetch, and it removes bytes whenever the host's queue status says the host took a byte or emptied its queue. Bus cycles run by other masters are recognised through a bus-owner status bit and are not taken.

While it follows the queue, the tracker watches each opcode byte the host decodes. If the opcode belongs to the escape class, the tracker waits for the next byte the host removes, which is the addressing byte. It then pulses a strobe for one cycle with an 11-bit payload and a flag that separates memory-operand forms from register forms. A coprocessor-style unit downstream uses the strobe and payload to start its own work. The block carries out none of the decoded operations and does not capture any memory operand.

Top module: `iq_shadow_tracker`

## Requirements
- R1: A code fetch is taken on a clock edge where busStatus is 3'b100, busOwner is 0 and tState is 2'b10 (the data phase; 2'b00, 2'b01 and 2'b11 are the other phases). With wideHost=1 the fetch appends dataBus[7:0] and then dataBus[15:8]. With wideHost=0 it appends dataBus[7:0] only. A byte removal in the same cycle takes the oldest byte before the new bytes are appended.
- R2: A cycle with busOwner=1, a busStatus other than 3'b100, or a tState other than 2'b10 adds no byte to the queue.
- R3: The queue holds at most 6 bytes when wideHost=1 and 4 bytes when wideHost=0. A fetch that would exceed this limit is dropped as a whole, and the count is judged before any removal in the same cycle.
- R4: queueStatus 2'b01 (opcode byte taken) and 2'b11 (later byte taken) each remove the oldest byte. queueStatus 2'b00 removes nothing. A removal on an empty queue has no effect.
- R5: queueStatus 2'b10 empties the queue, drops any fetch in the same cycle, and cancels an escape that is waiting for its addressing byte.
- R6: An opcode byte removed with queueStatus 2'b01 is an escape when its bits 7:3 equal 5'b11011. Any other opcode produces no strobe.
- R7: escValid is high for exactly the one cycle after the edge at which the byte that directly follows an escape opcode is removed with queueStatus 2'b11. At that time escPayload = {opcode[2:0], addressing byte[7:0]}. If another opcode removal comes first, the escape is abandoned.
- R8: With escValid high, memForm is 1 when bits 7:6 of the addressing byte are 00, 01 or 10, and 0 when they are 11.
- R9: After reset the queue is empty, no escape is waiting, and escValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busStatus | input | 3 | Host bus cycle type; 3'b100 is a code fetch |
| busOwner | input | 1 | 0 when the host owns the current bus cycle |
| queueStatus | input | 2 | Host queue action: 00 none, 01 opcode byte, 10 empty, 11 later byte |
| dataBus | input | 16 | Local data bus |
| tState | input | 2 | Bus phase; 2'b10 is the data phase |
| wideHost | input | 1 | 1 for a 16-bit host, 0 for an 8-bit host |
| escValid | output | 1 | One-cycle strobe for a decoded escape |
| escPayload | output | 11 | Low opcode bits and addressing byte |
| memForm | output | 1 | Escape names a memory operand |

## Verification
The assertions check on every cycle that the fill level stays within the limit for the current host width, that an empty command leaves the queue at zero on the next cycle, that idle queue status with a foreign bus owner leaves the fill level unchanged, that the strobe lasts one cycle and follows a later-byte removal, and that memForm matches the MOD bits of the payload. Only the bench scenarios can show that bytes come out in the order they went in, that every one of the 256 opcode values is classified correctly for both host widths, and that fetches at the depth limit, fetches from foreign masters, fetches in the wrong phase, removals on an empty queue and abandoned escapes leave the strobe silent.

// File: rtl/iq_shadow_pkg.sv
package iq_shadow_pkg;

  localparam logic [2:0] BS_CODE    = 3'b100;
  localparam logic [1:0] T_DATA     = 2'b10;
  localparam logic [1:0] QS_IDLE    = 2'b00;
  localparam logic [1:0] QS_FIRST   = 2'b01;
  localparam logic [1:0] QS_FLUSH   = 2'b10;
  localparam logic [1:0] QS_NEXT    = 2'b11;
  localparam logic [4:0] ESC_PREFIX = 5'b11011;
  localparam int         ESC_PAY_W  = 11;

  // strobes from control to the queue datapath
  typedef struct packed {
    logic pushLo;
    logic pushHi;
    logic pop;
    logic flush;
  } qStrobes_t;

endpackage

// File: rtl/iq_shadow_dp.sv
module iq_shadow_dp
  import iq_shadow_pkg::*;
#(
  parameter int MAX_DEPTH = 6,
  localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  qStrobes_t        strb,
  input  logic [15:0]      fetchWord,
  output logic [7:0]       headByte,
  output logic [CNT_W-1:0] fillCount
);

  logic [7:0]       queue [MAX_DEPTH];
  logic [7:0]       nextQ [MAX_DEPTH];
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] base;

  always_comb begin
    nextQ   = queue;
    nextCnt = fillCount;
    base    = '0;
    if (strb.flush) begin
      nextCnt = '0;
    end else begin
      if (strb.pop) begin
        for (int i = 0; i < MAX_DEPTH - 1; i++) nextQ[i] = queue[i+1];
        nextQ[MAX_DEPTH-1] = '0;
        nextCnt = fillCount - CNT_W'(1);
      end
      base = nextCnt;
      if (strb.pushLo) begin
        for (int i = 0; i < MAX_DEPTH; i++)
          if (CNT_W'(i) == base) nextQ[i] = fetchWord[7:0];
        nextCnt = nextCnt + CNT_W'(1);
      end
      if (strb.pushHi) begin
        for (int i = 0; i < MAX_DEPTH; i++)
          if (CNT_W'(i) == base + CNT_W'(1)) nextQ[i] = fetchWord[15:8];
        nextCnt = nextCnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
      for (int i = 0; i < MAX_DEPTH; i++) queue[i] <= '0;
    end else begin
      fillCount <= nextCnt;
      queue     <= nextQ;
    end
  end

  assign headByte = queue[0];

endmodule

// File: rtl/iq_shadow_ctrl.sv
module iq_shadow_ctrl
  import iq_shadow_pkg::*;
#(
  parameter int WIDE_DEPTH   = 6,
  parameter int NARROW_DEPTH = 4,
  localparam int CNT_W = $clog2(WIDE_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           busStatus,
  input  logic                 busOwner,
  input  logic [1:0]           queueStatus,
  input  logic [1:0]           tState,
  input  logic                 wideHost,
  input  logic [7:0]           headByte,
  input  logic [CNT_W-1:0]     fillCount,
  output qStrobes_t            strb,
  output logic                 escValid,
  output logic [ESC_PAY_W-1:0] escPayload,
  output logic                 memForm
);

  logic             isFlush, fetchSeen, hasRoom;
  logic [CNT_W:0]   sumNeed, depthNow;
  logic             escPending;
  logic [2:0]       opLow;

  assign isFlush   = (queueStatus == QS_FLUSH);
  assign fetchSeen = (busStatus == BS_CODE) && !busOwner && (tState == T_DATA);
  assign sumNeed   = {1'b0, fillCount} + (wideHost ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
  assign depthNow  = wideHost ? (CNT_W+1)'(WIDE_DEPTH) : (CNT_W+1)'(NARROW_DEPTH);
  assign hasRoom   = (sumNeed <= depthNow);

  always_comb begin
    strb.flush  = isFlush;
    strb.pop    = ((queueStatus == QS_FIRST) || (queueStatus == QS_NEXT)) && (fillCount != '0);
    strb.pushLo = fetchSeen && !isFlush && hasRoom;
    strb.pushHi = fetchSeen && !isFlush && hasRoom && wideHost;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      escPending <= 1'b0;
      opLow      <= '0;
      escValid   <= 1'b0;
      escPayload <= '0;
      memForm    <= 1'b0;
    end else begin
      escValid <= 1'b0;
      if (isFlush) begin
        escPending <= 1'b0;
      end else if (strb.pop && queueStatus == QS_FIRST) begin
        escPending <= (headByte[7:3] == ESC_PREFIX);
        opLow      <= headByte[2:0];
      end else if (strb.pop && queueStatus == QS_NEXT) begin
        escPending <= 1'b0;
        if (escPending) begin
          escValid   <= 1'b1;
          escPayload <= {opLow, headByte};
          memForm    <= (headByte[7:6] != 2'b11);
        end
      end
    end
  end

endmodule

// File: rtl/iq_shadow_tracker.sv
module iq_shadow_tracker
  import iq_shadow_pkg::*;
#(
  parameter int WIDE_DEPTH   = 6,
  parameter int NARROW_DEPTH = 4,
  localparam int CNT_W = $clog2(WIDE_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           busStatus,
  input  logic                 busOwner,
  input  logic [1:0]           queueStatus,
  input  logic [15:0]          dataBus,
  input  logic [1:0]           tState,
  input  logic                 wideHost,
  output logic                 escValid,
  output logic [ESC_PAY_W-1:0] escPayload,
  output logic                 memForm
);

  qStrobes_t        strb;
  logic [7:0]       headByte;
  logic [CNT_W-1:0] fillCount;

  iq_shadow_ctrl #(.WIDE_DEPTH(WIDE_DEPTH), .NARROW_DEPTH(NARROW_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .busStatus(busStatus), .busOwner(busOwner),
    .queueStatus(queueStatus), .tState(tState), .wideHost(wideHost),
    .headByte(headByte), .fillCount(fillCount), .strb(strb),
    .escValid(escValid), .escPayload(escPayload), .memForm(memForm)
  );

  iq_shadow_dp #(.MAX_DEPTH(WIDE_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchWord(dataBus),
    .headByte(headByte), .fillCount(fillCount)
  );

endmodule

// File: rtl/iq_shadow_chk.sv
module iq_shadow_chk
  import iq_shadow_pkg::*;
#(
  parameter int WIDE_DEPTH   = 6,
  parameter int NARROW_DEPTH = 4,
  localparam int CNT_W = $clog2(WIDE_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busOwner,
  input logic [1:0]           queueStatus,
  input logic                 wideHost,
  input logic [CNT_W-1:0]     fillCount,
  input logic                 escValid,
  input logic [ESC_PAY_W-1:0] escPayload,
  input logic                 memForm
);

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    int'(fillCount) <= (wideHost ? WIDE_DEPTH : NARROW_DEPTH)); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    queueStatus == QS_FLUSH |=> fillCount == '0); // R5

  AST_FOREIGN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busOwner && queueStatus == QS_IDLE) |=> $stable(fillCount)); // R2

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    escValid |=> !escValid); // R7

  AST_STROBE_AFTER_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(escValid) |-> $past(queueStatus) == QS_NEXT); // R7

  AST_MEM_FORM: assert property (@(posedge clk) disable iff (!rstN)
    escValid |-> (memForm == (escPayload[7:6] != 2'b11))); // R8

endmodule

bind iq_shadow_tracker iq_shadow_chk #(.WIDE_DEPTH(WIDE_DEPTH), .NARROW_DEPTH(NARROW_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busOwner(busOwner), .queueStatus(queueStatus),
  .wideHost(wideHost), .fillCount(fillCount), .escValid(escValid),
  .escPayload(escPayload), .memForm(memForm)
);

// File: tb/iq_shadow_tracker_test.sv
module iq_shadow_tracker_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busStatus = 3'b111;
  logic        busOwner = 1'b0;
  logic [1:0]  queueStatus = 2'b00;
  logic [15:0] dataBus = '0;
  logic [1:0]  tState = 2'b00;
  logic        wideHost = 1'b1;
  logic        escValid;
  logic [10:0] escPayload;
  logic        memForm;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  iq_shadow_tracker uut (
    .clk(clk), .rstN(rstN), .busStatus(busStatus), .busOwner(busOwner),
    .queueStatus(queueStatus), .dataBus(dataBus), .tState(tState),
    .wideHost(wideHost), .escValid(escValid), .escPayload(escPayload),
    .memForm(memForm)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] bs, input logic own, input logic [1:0] ts,
                      input logic [1:0] qs, input logic [15:0] d);
    busStatus = bs; busOwner = own; tState = ts; queueStatus = qs; dataBus = d;
    @(negedge clk);
  endtask

  task automatic idle();        step(3'b111, 1'b0, 2'b00, 2'b00, 16'h0); endtask
  task automatic flushQ();      step(3'b111, 1'b0, 2'b00, 2'b10, 16'h0); endtask
  task automatic popFirst();    step(3'b111, 1'b0, 2'b00, 2'b01, 16'h0); endtask
  task automatic popNext();     step(3'b111, 1'b0, 2'b00, 2'b11, 16'h0); endtask
  task automatic fetch(input logic [15:0] d); step(3'b100, 1'b0, 2'b10, 2'b00, d); endtask

  task automatic loadPair(input logic [7:0] op, input logic [7:0] sec);
    if (wideHost) fetch({sec, op});
    else begin
      fetch({8'h5A, op});
      fetch({8'hA5, sec});
    end
  endtask

  task automatic expectNone(input string tag);
    check(escValid == 1'b0, tag, escValid, 0);
  endtask

  task automatic expectEsc(input logic [7:0] op, input logic [7:0] sec, input string tag);
    logic [10:0] pay;
    logic mf;
    pay = {op[2:0], sec};
    mf  = (sec[7:6] != 2'b11);
    check(escValid == 1'b1, {tag, " strobe"}, escValid, 1);
    if (escValid) begin
      check(escPayload == pay, {tag, " payload R7"}, escPayload, pay);
      check(memForm == mf, {tag, " memForm R8"}, memForm, mf);
    end
  endtask

  task automatic runPair(input logic [7:0] op, input logic [7:0] sec);
    flushQ();
    loadPair(op, sec);
    popFirst();
    expectNone("R7 no strobe on opcode removal");
    popNext();
    if (op[7:3] == 5'b11011) expectEsc(op, sec, "R6");
    else expectNone("R6 non-escape opcode");
    idle();
    expectNone("R7 strobe lasts one cycle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] secs [4];
    secs[0] = 8'h05; secs[1] = 8'h46; secs[2] = 8'h87; secs[3] = 8'hC3;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectNone("R9 reset strobe");
    // R9: a reset queue is empty, so removals find nothing
    popFirst(); popNext();
    expectNone("R9 empty after reset");

    // R1 R6 R7 R8: wide host, every opcode with each MOD value
    wideHost = 1'b1;
    for (int op = 0; op < 256; op++)
      for (int m = 0; m < 4; m++) runPair(8'(op), secs[m]);

    // R1 R6: narrow host, low byte only, every opcode
    wideHost = 1'b0;
    for (int op = 0; op < 256; op++) runPair(8'(op), 8'(op) ^ 8'hC9);

    // R2: foreign owner, wrong cycle type, wrong phase take no bytes
    wideHost = 1'b1;
    for (int v = 0; v < 3; v++) begin
      flushQ();
      if (v == 0) step(3'b100, 1'b1, 2'b10, 2'b00, 16'hC1D9);
      if (v == 1) step(3'b101, 1'b0, 2'b10, 2'b00, 16'hC1D9);
      if (v == 2) step(3'b100, 1'b0, 2'b01, 2'b00, 16'hC1D9);
      fetch(16'h9090);
      popFirst(); popNext();
      expectNone("R2 ignored bus cycle");
    end

    // R3: wide limit, fourth word dropped
    flushQ();
    fetch(16'h9090); fetch(16'h9090); fetch(16'h9090); fetch(16'hC1D9);
    for (int k = 0; k < 6; k++) popFirst();
    popFirst(); popNext();
    expectNone("R3 wide over-limit fetch dropped");
    // R3: wide exact fill accepted
    flushQ();
    fetch(16'h9090); fetch(16'h9090); fetch(16'hC1D9);
    for (int k = 0; k < 4; k++) popFirst();
    popFirst(); popNext();
    expectEsc(8'hD9, 8'hC1, "R3 wide exact fill");

    // R3: narrow limit
    wideHost = 1'b0;
    flushQ();
    for (int k = 0; k < 4; k++) fetch(16'h0090);
    fetch(16'h00D9); fetch(16'h0041);
    for (int k = 0; k < 4; k++) popFirst();
    popFirst(); popNext();
    expectNone("R3 narrow over-limit fetch dropped");
    flushQ();
    fetch(16'h0090); fetch(16'h0090); fetch(16'h00DD); fetch(16'h0041);
    popFirst(); popFirst(); popFirst(); popNext();
    expectEsc(8'hDD, 8'h41, "R3 narrow exact fill");

    // R4: removals on an empty queue do not disturb later bytes
    wideHost = 1'b1;
    flushQ();
    popFirst(); popNext();
    fetch(16'hC2DA);
    popFirst(); popNext();
    expectEsc(8'hDA, 8'hC2, "R4 empty removal ignored");

    // R1 R4: removal and fetch in one cycle keep byte order
    flushQ();
    fetch(16'h9190);
    step(3'b100, 1'b0, 2'b10, 2'b01, 16'hC4DB);
    popFirst(); popFirst(); popNext();
    expectEsc(8'hDB, 8'hC4, "R1 same-cycle order");

    // R5: empty command cancels a waiting escape
    flushQ();
    fetch(16'hC1D9);
    popFirst();
    flushQ();
    fetch(16'h9090);
    popNext();
    expectNone("R5 flush cancels pending escape");
    // R5: fetch in the flush cycle is dropped
    flushQ();
    step(3'b100, 1'b0, 2'b10, 2'b10, 16'hC1D9);
    popFirst(); popNext();
    expectNone("R5 fetch during flush dropped");

    // R7: an intervening opcode removal abandons the escape
    flushQ();
    fetch(16'h90D9); fetch(16'hC391);
    popFirst(); popFirst();
    expectNone("R7 intervening opcode");
    popFirst(); popNext();
    expectNone("R7 abandoned escape");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule